// File: doc/BRIEF.md
# Branch Target Buffer Predictor with Static Fallback

This block predicts the direction and the target of a branch for an instruction fetch unit. A direct-mapped table, addressed by the low word-address bits of the program counter, holds for each entry a valid flag, an address tag, the last taken target and a four-state saturating direction automaton. A lookup is purely combinational. When the entry matches, the automaton supplies the direction and the entry supplies the target. When it does not match, a static rule takes over. That rule predicts a backward branch (negative displacement) taken and a forward branch not taken, and its target is the PC plus the displacement.

A resolved branch is reported on the update port and takes effect at the next clock edge. If that branch hits, its entry is trained. If it misses, a new entry is allocated in its slot. The lookup path has no back-pressure: a new prediction is produced every cycle. The update port has a valid qualifier but no ready signal, because the table accepts one update per cycle unconditionally.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports `lk_hit`=0.
- R2: A lookup whose index bits `pc[OFS_W+IDX_W-1:OFS_W]` select a valid entry with an equal tag `pc[PC_W-1:OFS_W+IDX_W]` reports `lk_hit`=1 and drives `lk_target` with the stored target.
- R3: The direction state is a 4-bit one-hot code: 0001 strongly not-taken, 0010 weakly not-taken, 0100 weakly taken, 1000 strongly taken. A taken outcome moves it one step toward 1000 and a not-taken outcome moves it one step toward 0001. It saturates at both ends and never wraps.
- R4: On a hit, `lk_taken` is 1 exactly when the entry is in state 0100 or 1000.
- R5: On a miss, `lk_taken` equals the sign bit of `lk_disp`, so a negative displacement is predicted taken.
- R6: On a miss, `lk_target` equals `lk_pc + lk_disp` modulo 2^PC_W.
- R7: An update that misses allocates the slot. It writes the tag and `upd_target`, and sets the state to 0100 if `upd_taken`, otherwise to 0010. Any other branch held in that slot is displaced.
- R8: An update that hits steps the state as in R3. It overwrites the stored target only when `upd_taken` is 1.
- R9: An update is visible to lookups from the cycle after the clock edge at which `upd_valid` is high. A lookup in the same cycle sees the old contents.
- R10: Two PCs that share an index but differ in tag never hit on each other's entry.
- R11: An alternating taken/not-taken outcome sequence on an entry allocated taken makes the prediction alternate between taken and not-taken. In that case the state swings between 0100 and 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all valid flags |
| lk_pc | input | PC_W | PC of the branch being fetched |
| lk_disp | input | PC_W | Signed displacement of that branch, used on a miss |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_taken | output | 1 | Predicted direction |
| lk_target | output | PC_W | Predicted target |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | PC_W | Resolved target |

## Verification
The bench targets saturation at both ends. A design that wraps would flip a strongly-taken entry to not-taken after one more taken outcome. It also drives alternating outcomes: if the initial allocation state were wrong, the prediction would stop alternating or lag by one. Aliasing PCs that share an index are used to expose a missing or truncated tag compare, which would produce false hits with the wrong target. Not-taken updates on hits are used to catch a design that clobbers the stored target. Same-cycle lookup and update at one PC show whether the write leaks combinationally into the lookup.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [3:0] dir_state_t;
  localparam dir_state_t ST_SNT = 4'b0001;
  localparam dir_state_t ST_WNT = 4'b0010;
  localparam dir_state_t ST_WT  = 4'b0100;
  localparam dir_state_t ST_ST  = 4'b1000;

  function automatic logic dir_of(input dir_state_t s);
    return s[3] | s[2];
  endfunction
endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int TAG_W = 21,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output logic             ra_valid,
  output logic [TAG_W-1:0] ra_tag,
  output logic [PC_W-1:0]  ra_tgt,
  output dir_state_t       ra_state,
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_valid,
  output logic [TAG_W-1:0] rb_tag,
  output dir_state_t       rb_state,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  logic             w_tgt_en,
  input  logic [PC_W-1:0]  w_tgt,
  input  dir_state_t       w_state
);
  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_q   [DEPTH];
  logic [PC_W-1:0]  tgt_q   [DEPTH];
  dir_state_t       state_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (we) vld_q[w_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[w_idx]   <= w_tag;
      state_q[w_idx] <= w_state;
      if (w_tgt_en) tgt_q[w_idx] <= w_tgt;
    end
  end

  assign ra_valid = vld_q[ra_idx];
  assign ra_tag   = tag_q[ra_idx];
  assign ra_tgt   = tgt_q[ra_idx];
  assign ra_state = state_q[ra_idx];
  assign rb_valid = vld_q[rb_idx];
  assign rb_tag   = tag_q[rb_idx];
  assign rb_state = state_q[rb_idx];
endmodule

// File: rtl/btb_automaton.sv
module btb_automaton
  import btb_pkg::*;
(
  input  dir_state_t cur,
  input  logic       alloc,
  input  logic       taken,
  output dir_state_t nxt
);
  always_comb begin
    if (alloc)      nxt = taken ? ST_WT : ST_WNT;
    else if (taken) nxt = cur[3] ? cur : {cur[2:0], 1'b0};
    else            nxt = cur[0] ? cur : {1'b0, cur[3:1]};
  end
endmodule

// File: rtl/btb_static.sv
module btb_static #(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] disp,
  output logic            dir,
  output logic [PC_W-1:0] tgt
);
  assign dir = disp[PC_W-1];
  assign tgt = pc + disp;
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int DEPTH = 512,
  parameter int OFS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  input  logic [PC_W-1:0] lk_disp,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_target,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_W = PC_W - IDX_W - OFS_W;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  assign lk_idx = lk_pc[OFS_W +: IDX_W];
  assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
  assign up_idx = upd_pc[OFS_W +: IDX_W];
  assign up_tag = upd_pc[PC_W-1 -: TAG_W];

  logic unused_upd_low;
  assign unused_upd_low = ^upd_pc[OFS_W-1:0];

  logic             rd_valid, ub_valid;
  logic [TAG_W-1:0] rd_tag, ub_tag;
  logic [PC_W-1:0]  rd_tgt;
  dir_state_t       rd_state, ub_state, nx_state;
  logic             upd_hit;

  btb_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PC_W(PC_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(lk_idx), .ra_valid(rd_valid), .ra_tag(rd_tag), .ra_tgt(rd_tgt), .ra_state(rd_state),
    .rb_idx(up_idx), .rb_valid(ub_valid), .rb_tag(ub_tag), .rb_state(ub_state),
    .we(upd_valid), .w_idx(up_idx), .w_tag(up_tag),
    .w_tgt_en(!upd_hit || upd_taken), .w_tgt(upd_target), .w_state(nx_state)
  );

  assign upd_hit = ub_valid && (ub_tag == up_tag);

  btb_automaton u_fsm (
    .cur(ub_state), .alloc(!upd_hit), .taken(upd_taken), .nxt(nx_state)
  );

  logic            st_dir;
  logic [PC_W-1:0] st_tgt;
  btb_static #(.PC_W(PC_W)) u_static (
    .pc(lk_pc), .disp(lk_disp), .dir(st_dir), .tgt(st_tgt)
  );

  assign lk_hit    = rd_valid && (rd_tag == lk_tag);
  assign lk_taken  = lk_hit ? dir_of(rd_state) : st_dir;
  assign lk_target = lk_hit ? rd_tgt : st_tgt;
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] lk_pc,
  input logic [PC_W-1:0] lk_disp,
  input logic            lk_hit,
  input logic            lk_taken,
  input logic [PC_W-1:0] lk_target,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target,
  input logic [3:0]      rd_state
);
  // R3: stored direction state is always one of the four one-hot codes
  p_state_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $countones(rd_state) == 1);

  // R4: a taken prediction on a hit comes from a taken-side state
  p_hit_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_taken) |-> (rd_state[3] || rd_state[2]));

  // R5: miss falls back to the displacement sign
  p_static_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_taken == lk_disp[PC_W-1]);

  // R6: miss target is pc plus displacement
  p_static_tgt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_target == lk_pc + lk_disp);

  // R9, R7: an update is a hit for the same pc on the next cycle
  p_alloc_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(upd_valid) && lk_pc == $past(upd_pc)) |-> lk_hit);

  // R8: a taken update leaves its target in the entry
  p_taken_tgt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(upd_valid) && $past(upd_taken) && lk_pc == $past(upd_pc))
      |-> lk_target == $past(upd_target));
endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_disp(lk_disp), .lk_hit(lk_hit),
  .lk_taken(lk_taken), .lk_target(lk_target), .upd_valid(upd_valid), .upd_pc(upd_pc),
  .upd_taken(upd_taken), .upd_target(upd_target), .rd_state(rd_state)
);

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
  localparam int PC_W = 32, DEPTH = 512, OFS_W = 2;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] lk_pc = '0, lk_disp = '0, upd_pc = '0, upd_target = '0;
  logic upd_valid = 0, upd_taken = 0;
  logic lk_hit, lk_taken;
  logic [PC_W-1:0] lk_target;

  btb_predictor #(.PC_W(PC_W), .DEPTH(DEPTH), .OFS_W(OFS_W)) uut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // reference model: state 0=SNT 1=WNT 2=WT 3=ST
  bit              m_vld [DEPTH];
  logic [PC_W-1:0] m_pc  [DEPTH];
  logic [PC_W-1:0] m_tgt [DEPTH];
  int              m_st  [DEPTH];

  function automatic int idx_of(input logic [PC_W-1:0] pc);
    return int'(pc[OFS_W +: IDX_W]);
  endfunction

  function automatic bit same_tag(input logic [PC_W-1:0] a, input logic [PC_W-1:0] b);
    return a[PC_W-1:OFS_W+IDX_W] == b[PC_W-1:OFS_W+IDX_W];
  endfunction

  task automatic model_update(input logic [PC_W-1:0] pc, input bit t, input logic [PC_W-1:0] tg);
    int i = idx_of(pc);
    if (m_vld[i] && same_tag(m_pc[i], pc)) begin
      if (t) begin m_st[i] = (m_st[i] == 3) ? 3 : m_st[i] + 1; m_tgt[i] = tg; end
      else   m_st[i] = (m_st[i] == 0) ? 0 : m_st[i] - 1;
    end else begin
      m_vld[i] = 1; m_pc[i] = pc; m_tgt[i] = tg; m_st[i] = t ? 2 : 1;
    end
  endtask

  // one cycle: drive at negedge, check the combinational lookup, then model the edge
  task automatic step(input logic [PC_W-1:0] lpc, input logic [PC_W-1:0] ldisp,
                      input bit uv, input logic [PC_W-1:0] upc, input bit ut,
                      input logic [PC_W-1:0] utg, input string req);
    int i;
    bit e_hit, e_tk;
    logic [PC_W-1:0] e_tg;
    @(negedge clk);
    lk_pc = lpc; lk_disp = ldisp;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
    #1;
    i = idx_of(lpc);
    e_hit = m_vld[i] && same_tag(m_pc[i], lpc);
    e_tk  = e_hit ? (m_st[i] >= 2) : ldisp[PC_W-1];
    e_tg  = e_hit ? m_tgt[i] : lpc + ldisp;
    n_chk++;
    if (lk_hit !== e_hit || lk_taken !== e_tk || lk_target !== e_tg) begin
      n_bad++;
      $display("FAIL %s pc=%h actual hit=%b tk=%b tgt=%h expected hit=%b tk=%b tgt=%h",
               req, lpc, lk_hit, lk_taken, lk_target, e_hit, e_tk, e_tg);
    end
    if (uv) model_update(upc, ut, utg);
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] d, input string req);
    step(pc, d, 0, '0, 0, '0, req);
  endtask

  task automatic train(input logic [PC_W-1:0] pc, input bit t, input logic [PC_W-1:0] tg, input string req);
    step(pc, 32'h10, 1, pc, t, tg, req);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] pool [16];
    void'($urandom(32'd1357));
    for (int k = 0; k < DEPTH; k++) begin m_vld[k] = 0; m_st[k] = 0; m_pc[k] = '0; m_tgt[k] = '0; end
    repeat (3) @(posedge clk);
    rst_n = 1;

    // R1: reset leaves the table empty; R5/R6 static fallback both signs
    look(32'h0000_1000, 32'hFFFF_FFF0, "R1 R5 R6 backward");
    look(32'h0000_2004, 32'h0000_0040, "R1 R5 R6 forward");
    look(32'hFFFF_FFFC, 32'h0000_0008, "R6 wrap");

    // R7, R9: allocate taken; same-cycle lookup still misses
    step(32'h0000_3000, 32'h20, 1, 32'h0000_3000, 1, 32'h0000_4444, "R9 same cycle old");
    look(32'h0000_3000, 32'h20, "R7 R2 alloc taken WT");
    // R3 saturation on the taken side
    repeat (4) train(32'h0000_3000, 1, 32'h0000_4444, "R3 up");
    train(32'h0000_3000, 0, 32'h0000_9999, "R8 nt keeps target");
    look(32'h0000_3000, 32'h20, "R3 ST->WT still taken, R8 target kept");
    // saturate low
    repeat (5) train(32'h0000_3000, 0, 32'h0, "R3 down");
    train(32'h0000_3000, 1, 32'h0000_5555, "R3 SNT->WNT");
    look(32'h0000_3000, 32'hFFFF_FF00, "R3 R4 WNT not taken, R8 new target");

    // R7 allocate not-taken, R11 alternation
    train(32'h0000_5008, 0, 32'h0000_6000, "R7 alloc nt");
    look(32'h0000_5008, 32'hFFFF_FFF0, "R7 WNT predicts nt");
    train(32'h0000_6008, 1, 32'h0000_7000, "R11 alloc taken");
    for (int k = 0; k < 8; k++) begin
      train(32'h0000_6008, k[0] == 0 ? 0 : 1, 32'h0000_7000, "R11 alternate");
      look(32'h0000_6008, 32'h4, "R11 alternate predict");
    end

    // R10: alias on same index, different tag
    look(32'h0000_6008 + (32'h1 << (OFS_W + IDX_W)), 32'h4, "R10 alias misses");
    train(32'h0000_6008 + (32'h1 << (OFS_W + IDX_W)), 1, 32'h0000_ABC0, "R7 displace");
    look(32'h0000_6008, 32'h4, "R10 R7 displaced entry misses");

    // random mix over a small pool with aliasing
    for (int k = 0; k < 16; k++)
      pool[k] = {$urandom_range(7, 0), 21'd0, 11'd0} | (($urandom_range(15, 0) & 32'hF) << OFS_W)
                | (32'h1 << (OFS_W + IDX_W + (k % 3)));
    for (int k = 0; k < 3000; k++) begin
      step(pool[$urandom_range(15, 0)], $urandom(), $urandom_range(1, 0) == 1,
           pool[$urandom_range(15, 0)], $urandom_range(1, 0) == 1, $urandom(), "R2 R4 random");
    end

    // R1: reset again clears everything
    @(negedge clk); rst_n = 0; upd_valid = 0;
    @(negedge clk); rst_n = 1;
    for (int k = 0; k < DEPTH; k++) m_vld[k] = 0;
    look(pool[0], 32'h8, "R1 after reset");
    look(32'h0000_3000, 32'hFFFF_FFFC, "R1 after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule